// File: doc/BRIEF.md
# Bit-Destuffing Serial Frame Receiver

This block sits behind a clock-and-data recovery stage and works only on bits that have already been sampled. Each cycle in which `bit_vld` is high delivers one line bit on `bit_in`. While idle, the block searches for a run of three ones that marks the start of a frame. Once a frame has started, it removes the filler ones that the sender places after every six consecutive zeros, then packs the remaining data bits into 16-bit words, most significant bit first.

The first word of a frame is a header. Its low ten bits give the number of 16-bit payload words that follow, from 0 up to 1023. Every word leaves the block with a one-cycle `word_vld` pulse. `word_sof` marks the header word and `word_eof` marks the final word of the frame. If a zero arrives where a filler one must appear, the block raises `stuff_err`, discards the rest of the frame and goes back to searching for the start pattern. Clock recovery, integrity checking and higher-layer decoding are handled by other blocks.

Top module: `destuff_frame_rx`

## Requirements
- R1: While searching, three consecutive accepted ones start a frame, and the next accepted bit is the header's most significant bit. Two ones followed by a zero do not start a frame.
- R2: A cycle with `bit_vld` low has no effect, whatever `bit_in` carries, and it produces no output pulse.
- R3: Inside a frame, the bit that follows six consecutive zero data bits is a filler. It must be one, and it is removed. Any one, data or filler, clears the zero-run count.
- R4: The filler rule applies from the first header bit onwards. For example, a header of 0x0000 is carried on the line with two fillers.
- R5: Words are assembled MSB first. `word_vld` is high for exactly one cycle: the cycle after the clock edge that accepts the word's 16th data bit.
- R6: The first word of every frame is the header, delivered with `word_sof`=1. Its bits [9:0] give the payload length, and its bits [15:10] are passed through but do not affect the length.
- R7: A header length of N>0 is followed by N payload words, and `word_eof`=1 marks the Nth. A length of 0 gives a single word that carries both `word_sof` and `word_eof`.
- R8: A length of 1023, the largest value, is received in full, with `word_eof` on the 1023rd payload word.
- R9: A zero in a filler position pulses `stuff_err` for one cycle, in the cycle after that bit is accepted. The frame's partial word and all its later bits are dropped, and the next start pattern begins a new frame.
- R10: While `rst_n` is low, all outputs are zero. A reset in the middle of a frame returns the block to searching.
- R11: When a frame ends, the block searches again at once, so a frame that ends on a one can be followed directly by the next frame's start pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Sampled line bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| word_data | output | 16 | Assembled word, held between pulses |
| word_vld | output | 1 | One-cycle strobe for `word_data` |
| word_sof | output | 1 | The word is a frame header |
| word_eof | output | 1 | The word is the last word of its frame |
| stuff_err | output | 1 | One-cycle pulse on a filler violation |

## Verification
The hardest case to reach from the ports is a filler violation deep inside a payload, after some words have already left the block. Reaching it needs a line stream that is correctly stuffed up to an exact bit and then breaks the rule at a filler slot. The bench builds every stream with its own stuffing routine and then appends raw zeros at a word boundary where its run count is known to be zero. It checks that the words already delivered stay free of `word_eof` and that the next frame is received cleanly. The longest frame, with all-zero payload words, drives the filler path thousands of times, and random `bit_vld` gaps are applied throughout.

// File: rtl/dsrx_pkg.sv
package dsrx_pkg;

  localparam int unsigned DEF_WORD_W    = 16;
  localparam int unsigned DEF_LEN_W     = 10;
  localparam int unsigned DEF_SYNC_ONES = 3;
  localparam int unsigned DEF_ZRUN_MAX  = 6;

  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_HDR  = 2'd1,
    RX_PAY  = 2'd2
  } rx_state_e;

  // Width of a counter that must hold 0..max_val.
  function automatic int unsigned ctr_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/dsrx_sync_hunt.sv
module dsrx_sync_hunt #(
  parameter int unsigned SYNC_ONES = dsrx_pkg::DEF_SYNC_ONES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hunting,
  input  logic bit_vld,
  input  logic bit_in,
  output logic sync_hit
);
  localparam int unsigned CW = dsrx_pkg::ctr_w(SYNC_ONES);

  logic [CW-1:0] ones_q;

  // The start pattern completes on the last of SYNC_ONES accepted ones.
  assign sync_hit = hunting && bit_vld && bit_in && (ones_q == CW'(SYNC_ONES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (!hunting) begin
      ones_q <= '0;
    end else if (bit_vld) begin
      if (!bit_in || sync_hit) ones_q <= '0;
      else                     ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsrx_unstuff.sv
module dsrx_unstuff #(
  parameter int unsigned ZRUN_MAX = dsrx_pkg::DEF_ZRUN_MAX,
  localparam int unsigned ZW = dsrx_pkg::ctr_w(ZRUN_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          bit_vld,
  input  logic          bit_in,
  output logic          data_vld,
  output logic          data_bit,
  output logic          stuff_drop,
  output logic          stuff_viol,
  output logic [ZW-1:0] zrun
);
  logic [ZW-1:0] zrun_q;
  logic          take;
  logic          slot_due;

  // Run-length step: any one clears, a zero extends, a filler slot restarts.
  function automatic logic [ZW-1:0] run_step(input logic [ZW-1:0] cur,
                                             input logic          b,
                                             input logic          filler);
    if (filler || b) return '0;
    return cur + 1'b1;
  endfunction

  assign take       = active && bit_vld;
  assign slot_due   = (zrun_q == ZW'(ZRUN_MAX));
  assign stuff_drop = take && slot_due && bit_in;
  assign stuff_viol = take && slot_due && !bit_in;
  assign data_vld   = take && !slot_due;
  assign data_bit   = bit_in;
  assign zrun       = zrun_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      zrun_q <= '0;
    else if (!active) zrun_q <= '0;
    else if (take)    zrun_q <= run_step(zrun_q, bit_in, slot_due);
  end
endmodule

// File: rtl/dsrx_deser.sv
module dsrx_deser #(
  parameter int unsigned WORD_W = dsrx_pkg::DEF_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              data_vld,
  input  logic              data_bit,
  output logic              word_done,
  output logic [WORD_W-1:0] word_next
);
  localparam int unsigned BW = dsrx_pkg::ctr_w(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic [BW-1:0]     cnt_q;

  // MSB first: earlier bits move toward the top.
  assign word_next = {shreg_q[WORD_W-2:0], data_bit};
  assign word_done = data_vld && (cnt_q == BW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (!active) begin
      cnt_q   <= '0;
    end else if (data_vld) begin
      shreg_q <= word_next;
      cnt_q   <= word_done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/destuff_frame_rx.sv
module destuff_frame_rx
  import dsrx_pkg::*;
#(
  parameter int unsigned WORD_W    = DEF_WORD_W,
  parameter int unsigned LEN_W     = DEF_LEN_W,
  parameter int unsigned SYNC_ONES = DEF_SYNC_ONES,
  parameter int unsigned ZRUN_MAX  = DEF_ZRUN_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic [WORD_W-1:0] word_data,
  output logic              word_vld,
  output logic              word_sof,
  output logic              word_eof,
  output logic              stuff_err
);
  localparam int unsigned ZW = ctr_w(ZRUN_MAX);

  rx_state_e         state_q;
  logic [LEN_W-1:0]  remain_q;
  logic [LEN_W-1:0]  hdr_len_w;

  // Named internal events, visible to the checker.
  logic              in_frame;
  logic              sync_hit;
  logic              data_vld;
  logic              data_bit;
  logic              stuff_drop;
  logic              stuff_viol;
  logic [ZW-1:0]     zrun;
  logic              word_done;
  logic [WORD_W-1:0] word_next;

  function automatic logic is_last(input logic [LEN_W-1:0] left);
    return left == LEN_W'(1);
  endfunction

  assign in_frame  = (state_q != RX_HUNT);
  assign hdr_len_w = word_next[LEN_W-1:0];

  dsrx_sync_hunt #(.SYNC_ONES(SYNC_ONES)) u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hunting  (!in_frame),
    .bit_vld  (bit_vld),
    .bit_in   (bit_in),
    .sync_hit (sync_hit)
  );

  dsrx_unstuff #(.ZRUN_MAX(ZRUN_MAX)) u_unstuff (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (in_frame),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .data_vld   (data_vld),
    .data_bit   (data_bit),
    .stuff_drop (stuff_drop),
    .stuff_viol (stuff_viol),
    .zrun       (zrun)
  );

  dsrx_deser #(.WORD_W(WORD_W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (in_frame),
    .data_vld  (data_vld),
    .data_bit  (data_bit),
    .word_done (word_done),
    .word_next (word_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_HUNT;
      remain_q  <= '0;
      word_data <= '0;
      word_vld  <= 1'b0;
      word_sof  <= 1'b0;
      word_eof  <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      word_vld  <= 1'b0;
      word_sof  <= 1'b0;
      word_eof  <= 1'b0;
      stuff_err <= 1'b0;
      unique case (state_q)
        RX_HUNT: begin
          if (sync_hit) state_q <= RX_HDR;
        end
        RX_HDR: begin
          if (stuff_viol) begin
            stuff_err <= 1'b1;
            state_q   <= RX_HUNT;
          end else if (word_done) begin
            word_data <= word_next;
            word_vld  <= 1'b1;
            word_sof  <= 1'b1;
            if (hdr_len_w == '0) begin
              word_eof <= 1'b1;
              state_q  <= RX_HUNT;
            end else begin
              remain_q <= hdr_len_w;
              state_q  <= RX_PAY;
            end
          end
        end
        RX_PAY: begin
          if (stuff_viol) begin
            stuff_err <= 1'b1;
            state_q   <= RX_HUNT;
          end else if (word_done) begin
            word_data <= word_next;
            word_vld  <= 1'b1;
            remain_q  <= remain_q - 1'b1;
            if (is_last(remain_q)) begin
              word_eof <= 1'b1;
              state_q  <= RX_HUNT;
            end
          end
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/dsrx_checker.sv
module dsrx_checker #(
  parameter int unsigned ZRUN_MAX = 6,
  parameter int unsigned ZW       = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_vld,
  input logic          word_vld,
  input logic          word_sof,
  input logic          word_eof,
  input logic          stuff_err,
  input logic          in_frame,
  input logic          stuff_drop,
  input logic          stuff_viol,
  input logic [ZW-1:0] zrun
);
  // Tracks whether a header has been seen without its closing word.
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     open_q <= 1'b0;
    else if (stuff_err)             open_q <= 1'b0;
    else if (word_vld && word_eof)  open_q <= 1'b0;
    else if (word_vld && word_sof)  open_q <= 1'b1;
  end

  assert_zrun_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zrun <= ZW'(ZRUN_MAX));

  assert_filler_no_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_drop |=> !word_vld);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> (!word_vld && !stuff_err));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  assert_flags_need_vld_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sof || word_eof) |-> word_vld);

  assert_payload_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !word_sof) |-> open_q);

  assert_err_follows_viol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_viol |=> stuff_err);

  assert_err_back_to_hunt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_err |-> (!in_frame && !word_vld));
endmodule

bind destuff_frame_rx dsrx_checker #(.ZRUN_MAX(ZRUN_MAX), .ZW(ZW)) u_dsrx_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_vld    (bit_vld),
  .word_vld   (word_vld),
  .word_sof   (word_sof),
  .word_eof   (word_eof),
  .stuff_err  (stuff_err),
  .in_frame   (in_frame),
  .stuff_drop (stuff_drop),
  .stuff_viol (stuff_viol),
  .zrun       (zrun)
);

// File: tb/tb_destuff_frame_rx.sv
module tb_destuff_frame_rx;
  localparam int WD_LIMIT = 150000;
  localparam int NCAP     = 1100;

  // {hdr top 6, length 10, base 16, step 16}
  localparam logic [47:0] VECS [0:7] = '{
    {6'h00, 10'd0,  16'h0000, 16'h0000},  // R7 zero length, R4 header fillers
    {6'h00, 10'd1,  16'h0000, 16'h0000},  // R3 all-zero payload
    {6'h00, 10'd3,  16'hFFFF, 16'h0000},  // R5 all ones
    {6'h00, 10'd4,  16'h8001, 16'h1111},  // R5 MSB order
    {6'h00, 10'd2,  16'h0040, 16'h0000},  // R3 runs across word edges
    {6'h2A, 10'd5,  16'h1234, 16'h0101},  // R6 upper header bits ignored
    {6'h3F, 10'd1,  16'h0001, 16'h0000},  // R1 header starts with ones
    {6'h00, 10'd20, 16'h0000, 16'h0001}   // R7 longer frame
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_in;
  logic        bit_vld;
  logic [15:0] word_data;
  logic        word_vld, word_sof, word_eof, stuff_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  int ng     = 0;
  int nerr   = 0;
  int tb_zrun = 0;
  int gap_mode = 0;
  logic [7:0] lfsr = 8'h5B;

  logic [15:0] got_w [0:NCAP-1];
  logic        got_s [0:NCAP-1];
  logic        got_e [0:NCAP-1];

  always #10 clk = ~clk;

  destuff_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .word_data(word_data), .word_vld(word_vld), .word_sof(word_sof),
    .word_eof(word_eof), .stuff_err(stuff_err)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (word_vld) begin
        if (ng < NCAP) begin
          got_w[ng] = word_data;
          got_s[ng] = word_sof;
          got_e[ng] = word_eof;
        end
        ng++;
      end
      if (stuff_err) nerr++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual cycles %0d expected below %0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic idle_cycle();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bit_vld = 1'b0;
    bit_in  = lfsr[0];
    @(negedge clk);
  endtask

  task automatic send_raw(input logic b);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (gap_mode == 2 || (gap_mode == 1 && lfsr[2:0] == 3'd0)) idle_cycle();
    bit_in  = b;
    bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  // Bench-side stuffing: a one after every sixth consecutive zero.
  task automatic send_data_bit(input logic b);
    send_raw(b);
    if (b) tb_zrun = 0;
    else begin
      tb_zrun++;
      if (tb_zrun == 6) begin
        send_raw(1'b1);
        tb_zrun = 0;
      end
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_data_bit(w[i]);
  endtask

  task automatic send_sync();
    send_raw(1'b1); send_raw(1'b1); send_raw(1'b1);
    tb_zrun = 0;
  endtask

  task automatic send_frame(input logic [5:0] ht, input logic [9:0] len,
                            input logic [15:0] base, input logic [15:0] step);
    send_sync();
    send_word({ht, len});
    for (int i = 0; i < int'(len); i++) send_word(base + 16'(i) * step);
  endtask

  task automatic idle_zeros(input int n);
    for (int i = 0; i < n; i++) send_raw(1'b0);
  endtask

  task automatic expect_frame(input int at, input logic [5:0] ht, input logic [9:0] len,
                              input logic [15:0] base, input logic [15:0] step, input string tag);
    for (int i = 0; i <= int'(len); i++) begin
      logic [15:0] ew;
      ew = (i == 0) ? {ht, len} : base + 16'(i - 1) * step;
      if (at + i < NCAP) begin
        chk(got_w[at+i] == ew && got_s[at+i] == (i == 0) && got_e[at+i] == (i == int'(len)),
            $sformatf("%s word %0d {data,sof,eof}", tag, i),
            {14'd0, got_w[at+i], got_s[at+i], got_e[at+i]},
            {14'd0, ew, 1'(i == 0), 1'(i == int'(len))});
      end
    end
  endtask

  task automatic run_frame(input logic [5:0] ht, input logic [9:0] len,
                           input logic [15:0] base, input logic [15:0] step, input string tag);
    ng = 0; nerr = 0;
    send_frame(ht, len, base, step);
    idle_zeros(3);
    chk(ng == int'(len) + 1, {tag, " word count"}, ng, int'(len) + 1);
    chk(nerr == 0, {tag, " no stuff_err"}, nerr, 0);
    expect_frame(0, ht, len, base, step, tag);
  endtask

  task automatic chk_quiet(input string tag);
    chk({word_vld, word_sof, word_eof, stuff_err} == 4'd0 && word_data == 16'd0,
        tag, {11'd0, word_data, word_vld, word_sof, word_eof, stuff_err}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; bit_in = 1'b0; bit_vld = 1'b0;
    repeat (3) @(negedge clk);
    chk_quiet("R10 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);

    // Table of frames, walked with random bit_vld gaps.
    gap_mode = 1;
    for (int k = 0; k < 8; k++) begin
      logic [47:0] v;
      v = VECS[k];
      run_frame(v[47:42], v[41:32], v[31:16], v[15:0],
                $sformatf("R3/R4/R6/R7 vector %0d", k));
    end

    // R5: pulse lands exactly after the 16th data bit (header 0x0000, length 0).
    gap_mode = 0; ng = 0; nerr = 0;
    send_sync();
    for (int i = 0; i < 15; i++) send_data_bit(1'b0);
    chk(word_vld == 1'b0, "R5 no pulse before 16th bit", word_vld, 0);
    send_data_bit(1'b0);
    chk(word_vld && word_sof && word_eof && word_data == 16'h0000,
        "R5 R7 pulse after 16th bit with sof+eof", {word_vld, word_sof, word_eof}, 3'b111);
    send_raw(1'b0);
    chk(word_vld == 1'b0, "R5 pulse lasts one cycle", word_vld, 0);
    idle_zeros(2);

    // R1: two ones then a zero must not start a frame.
    gap_mode = 1; ng = 0; nerr = 0;
    send_raw(1'b1); send_raw(1'b1); send_raw(1'b0);
    send_frame(6'h00, 10'd1, 16'hA5A5, 16'h0000);
    idle_zeros(3);
    chk(ng == 2, "R1 false start ignored, word count", ng, 2);
    expect_frame(0, 6'h00, 10'd1, 16'hA5A5, 16'h0000, "R1 after false start");

    // R2: a gap before every bit, with garbage on bit_in.
    gap_mode = 2;
    run_frame(6'h05, 10'd3, 16'h0F0F, 16'h1357, "R2 dense gaps");

    // R11: back-to-back frames, the first ending on a one.
    gap_mode = 1; ng = 0; nerr = 0;
    send_frame(6'h00, 10'd2, 16'h0003, 16'h0002);
    send_frame(6'h11, 10'd1, 16'hC0DE, 16'h0000);
    idle_zeros(3);
    chk(ng == 5, "R11 back-to-back word count", ng, 5);
    expect_frame(0, 6'h00, 10'd2, 16'h0003, 16'h0002, "R11 first");
    expect_frame(3, 6'h11, 10'd1, 16'hC0DE, 16'h0000, "R11 second");

    // R9: violation inside the header.
    gap_mode = 0; ng = 0; nerr = 0;
    send_sync();
    for (int i = 0; i < 6; i++) send_raw(1'b0);
    chk(stuff_err == 1'b0, "R9 no error before filler slot", stuff_err, 0);
    send_raw(1'b0);
    chk(stuff_err == 1'b1, "R9 stuff_err one cycle after bad filler", stuff_err, 1);
    send_raw(1'b0);
    chk(stuff_err == 1'b0, "R9 stuff_err single pulse", stuff_err, 0);
    idle_zeros(2);
    chk(ng == 0 && nerr == 1, "R9 header violation drops frame", {ng[15:0], nerr[15:0]}, {16'd0, 16'd1});
    run_frame(6'h00, 10'd1, 16'h7E7E, 16'h0000, "R9 recovery after header error");

    // R9: violation in the payload, after two words have left.
    gap_mode = 1; ng = 0; nerr = 0;
    send_sync();
    send_word(16'h0003);
    send_word(16'h0001);
    for (int i = 0; i < 7; i++) send_raw(1'b0);
    send_raw(1'b1); send_raw(1'b1);   // rest of the broken frame: ignored
    idle_zeros(4);
    chk(ng == 2 && nerr == 1, "R9 payload violation counts", {ng[15:0], nerr[15:0]}, {16'd2, 16'd1});
    chk(got_w[0] == 16'h0003 && got_s[0] && !got_e[0], "R9 header before error",
        {got_w[0], got_s[0], got_e[0]}, {16'h0003, 2'b10});
    chk(got_w[1] == 16'h0001 && !got_s[1] && !got_e[1], "R9 payload before error, no eof",
        {got_w[1], got_s[1], got_e[1]}, {16'h0001, 2'b00});
    run_frame(6'h01, 10'd2, 16'hBEEF, 16'h1000, "R9 recovery after payload error");

    // R10: reset in the middle of a header.
    gap_mode = 0;
    send_sync();
    for (int i = 0; i < 8; i++) send_data_bit(i[0]);
    rst_n = 1'b0;
    @(negedge clk);
    chk_quiet("R10 outputs during mid-frame reset");
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(6'h00, 10'd2, 16'h1111, 16'h2222, "R10 clean frame after reset");

    // R8: largest length, all-zero payload.
    gap_mode = 1;
    run_frame(6'h00, 10'd1023, 16'h0000, 16'h0000, "R8 max length");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule